// File: doc/BRIEF.md
# Power-Down Clock Gating and Reset Controller

This block is the power-down and reset section of a peripheral controller. It holds one static control register on the free-running host clock. The register carries a rate field, an oscillator-disable bit, a power-down bit and a self-clearing software-reset bit. From the two power-down bits and an external-oscillator select input, the block drives the run enables for the internal oscillator and the input buffer. It also drives the clock enable that the rest of the core uses.

An external hardware reset clears the control register asynchronously. The clear does not depend on the gated core clock, so a power-down bit that comes up set at power-on cannot block its own clearing. The core reset output asserts at once and is released through a short synchronizer. On the clock edge that ends the core reset, the block latches two strap inputs into one of three operating modes. That mode is held until the next hardware reset.

A software reset, issued through the register, pulses the core reset for one cycle. It leaves the strap mode and the two command flags (perpendicular mode and automatic power-down) untouched. The command flags are written by the core's command decoder. They update only while the core clock is enabled, and only a hardware reset clears them.

Top module: `pwrdn_rst_ctrl`

## Requirements
- R1: While `hw_reset` is high, the whole register reads 0, including the power-down bit (bit 6) and the oscillator-disable bit (bit 5). This happens without any clock edge and whatever the bits held before.
- R2: When register bit 6 is 1, `core_clk_en` and `buf_run` are 0.
- R3: When bit 5 is 1 and `ext_osc_sel` is 0, `core_clk_en` is 0. When `ext_osc_sel` is 1, bit 5 has no effect on `core_clk_en`. `osc_run` is always the inverse of bit 5.
- R4: The register accepts writes while `core_clk_en` is 0. Clearing bits 6 and 5 raises `core_clk_en` right after that write's clock edge.
- R5: `core_rst` rises as soon as `hw_reset` rises. It falls on the second rising clock edge after `hw_reset` falls.
- R6: On the edge where `core_rst` falls after a hardware reset, the straps are latched into `op_mode`:
  - `strap_id`=1 gives 2'b00.
  - `strap_id`=0 with `strap_enc`=1 gives 2'b01.
  - both 0 gives 2'b10.
  - Later strap changes have no effect.
- R7: Writing 1 to bit 7 raises `core_rst` for exactly one cycle. Bit 7 then reads 0, and bits 6:0 keep the written value.
- R8: A software reset changes neither `op_mode` nor `perp_mode` nor `auto_pd`.
- R9: A hardware reset clears `perp_mode` and `auto_pd`.
- R10: A `cmd_wr` pulse loads `cmd_perp`/`cmd_apd` into `perp_mode`/`auto_pd` on the next edge only when `core_clk_en` is 1. Otherwise the pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running host clock |
| hw_reset | input | 1 | External hardware reset, active high, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register contents |
| ext_osc_sel | input | 1 | External oscillator in use |
| strap_id | input | 1 | Identity strap |
| strap_enc | input | 1 | Encoding strap |
| cmd_wr | input | 1 | Command flag write strobe from the core decoder |
| cmd_perp | input | 1 | Perpendicular-mode flag value |
| cmd_apd | input | 1 | Automatic power-down flag value |
| osc_run | output | 1 | Internal oscillator enable |
| buf_run | output | 1 | Input buffer enable |
| core_clk_en | output | 1 | Internal core clock enable |
| core_rst | output | 1 | Core reset (hardware or software) |
| op_mode | output | 2 | Latched operating mode |
| perp_mode | output | 1 | Perpendicular-mode command flag |
| auto_pd | output | 1 | Automatic power-down command flag |

## Verification
The checker watches several rules on every clock:
- the gating of the clock enable by the power-down bits and the external-oscillator select, in both directions;
- the clear of the power-down bits and command flags during hardware reset;
- the one-cycle life of the software-reset bit;
- the stability of the mode and the flags outside their allowed update points.

The bench scenarios cover what needs an ordered stimulus:
- a register cleared mid-cycle with no clock edge;
- the exact edge on which the synchronized reset drops;
- each of the three strap decodes;
- flag writes dropped while the clock is gated;
- a software reset that must leave the mode and flags alone.

// File: rtl/pwrdn_rst_pkg.sv
package pwrdn_rst_pkg;

   typedef enum logic [1:0] {
      MODE_FIRST  = 2'b00,
      MODE_SECOND = 2'b01,
      MODE_THIRD  = 2'b10
   } op_mode_e;

   // identity strap has priority over the encoding strap
   function automatic op_mode_e decode_straps(input logic id, input logic enc);
      if (id)
         return MODE_FIRST;
      else if (enc)
         return MODE_SECOND;
      else
         return MODE_THIRD;
   endfunction

endpackage

// File: rtl/pwrdn_rst_sync.sv
module pwrdn_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic hw_reset,
   output logic core_rst_hw,
   output logic release_pulse
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pwrdn_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;

   // asserts asynchronously, releases through the chain
   always_ff @(posedge clk or posedge hw_reset) begin
      if (hw_reset)
         sync_q <= '1;
      else
         sync_q <= {sync_q[STAGES-2:0], 1'b0};
   end

   assign core_rst_hw   = sync_q[STAGES-1];
   assign release_pulse = sync_q[STAGES-1] & ~sync_q[STAGES-2];
endmodule

// File: rtl/pwrdn_ctrl_reg.sv
module pwrdn_ctrl_reg #(
   parameter int REG_W    = 8,
   parameter int SRST_BIT = 7
) (
   input  logic             clk,
   input  logic             hw_reset,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] reg_q
);
   if (SRST_BIT >= REG_W) begin : g_bad_srst
      $error("pwrdn_ctrl_reg: SRST_BIT outside register");
   end

   // clocked by the free-running host clock; cleared directly by the pin
   always_ff @(posedge clk or posedge hw_reset) begin
      if (hw_reset)
         reg_q <= '0;
      else if (wr_en)
         reg_q <= wr_data;
      else
         reg_q[SRST_BIT] <= 1'b0;
   end
endmodule

// File: rtl/pwrdn_clk_gate_ctl.sv
module pwrdn_clk_gate_ctl #(
   parameter bit HAS_OSC_PD = 1'b1
) (
   input  logic pd_bit,
   input  logic osc_pd_bit,
   input  logic ext_osc_sel,
   output logic osc_run,
   output logic buf_run,
   output logic clk_en
);
   assign buf_run = ~pd_bit;

   if (HAS_OSC_PD) begin : g_osc_pd
      assign osc_run = ~osc_pd_bit;
      assign clk_en  = buf_run & (osc_run | ext_osc_sel);
   end else begin : g_no_osc_pd
      logic unused_osc;
      assign unused_osc = osc_pd_bit ^ ext_osc_sel;
      assign osc_run    = 1'b1;
      assign clk_en     = buf_run;
   end
endmodule

// File: rtl/pwrdn_mode_latch.sv
module pwrdn_mode_latch
   import pwrdn_rst_pkg::*;
(
   input  logic     clk,
   input  logic     hw_reset,
   input  logic     core_rst_hw,
   input  logic     release_pulse,
   input  logic     strap_id,
   input  logic     strap_enc,
   input  logic     clk_en,
   input  logic     cmd_wr,
   input  logic     cmd_perp,
   input  logic     cmd_apd,
   output op_mode_e op_mode,
   output logic     perp_mode,
   output logic     auto_pd
);
   always_ff @(posedge clk or posedge hw_reset) begin
      if (hw_reset)
         op_mode <= MODE_FIRST;
      else if (release_pulse)
         op_mode <= decode_straps(strap_id, strap_enc);
   end

   // flags belong to the gated core: only hardware reset clears them
   always_ff @(posedge clk or posedge hw_reset) begin
      if (hw_reset) begin
         perp_mode <= 1'b0;
         auto_pd   <= 1'b0;
      end else if (core_rst_hw) begin
         perp_mode <= 1'b0;
         auto_pd   <= 1'b0;
      end else if (cmd_wr && clk_en) begin
         perp_mode <= cmd_perp;
         auto_pd   <= cmd_apd;
      end
   end
endmodule

// File: rtl/pwrdn_rst_ctrl.sv
module pwrdn_rst_ctrl
   import pwrdn_rst_pkg::*;
#(
   parameter int REG_W       = 8,
   parameter int OSC_PD_BIT  = 5,
   parameter int PD_BIT      = 6,
   parameter int SRST_BIT    = 7,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_OSC_PD  = 1'b1
) (
   input  logic             clk,
   input  logic             hw_reset,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             ext_osc_sel,
   input  logic             strap_id,
   input  logic             strap_enc,
   input  logic             cmd_wr,
   input  logic             cmd_perp,
   input  logic             cmd_apd,
   output logic             osc_run,
   output logic             buf_run,
   output logic             core_clk_en,
   output logic             core_rst,
   output logic [1:0]       op_mode,
   output logic             perp_mode,
   output logic             auto_pd
);
   localparam int MAX_BIT = REG_W - 1;

   if (OSC_PD_BIT > MAX_BIT || PD_BIT > MAX_BIT || SRST_BIT > MAX_BIT) begin : g_bad_pos
      $error("pwrdn_rst_ctrl: control bit outside register");
   end
   if (OSC_PD_BIT == PD_BIT || OSC_PD_BIT == SRST_BIT || PD_BIT == SRST_BIT) begin : g_overlap
      $error("pwrdn_rst_ctrl: control bits overlap");
   end

   logic [REG_W-1:0] reg_q;
   logic             hw_rst_core;
   logic             release_pulse;
   op_mode_e         mode_q;

   pwrdn_rst_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk          (clk),
      .hw_reset     (hw_reset),
      .core_rst_hw  (hw_rst_core),
      .release_pulse(release_pulse)
   );

   pwrdn_ctrl_reg #(
      .REG_W   (REG_W),
      .SRST_BIT(SRST_BIT)
   ) u_reg (
      .clk     (clk),
      .hw_reset(hw_reset),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .reg_q   (reg_q)
   );

   pwrdn_clk_gate_ctl #(
      .HAS_OSC_PD(HAS_OSC_PD)
   ) u_gate (
      .pd_bit     (reg_q[PD_BIT]),
      .osc_pd_bit (reg_q[OSC_PD_BIT]),
      .ext_osc_sel(ext_osc_sel),
      .osc_run    (osc_run),
      .buf_run    (buf_run),
      .clk_en     (core_clk_en)
   );

   pwrdn_mode_latch u_mode (
      .clk          (clk),
      .hw_reset     (hw_reset),
      .core_rst_hw  (hw_rst_core),
      .release_pulse(release_pulse),
      .strap_id     (strap_id),
      .strap_enc    (strap_enc),
      .clk_en       (core_clk_en),
      .cmd_wr       (cmd_wr),
      .cmd_perp     (cmd_perp),
      .cmd_apd      (cmd_apd),
      .op_mode      (mode_q),
      .perp_mode    (perp_mode),
      .auto_pd      (auto_pd)
   );

   assign rd_data  = reg_q;
   assign core_rst = hw_rst_core | reg_q[SRST_BIT];
   assign op_mode  = mode_q;
endmodule

// File: rtl/pwrdn_rst_ctrl_chk.sv
module pwrdn_rst_ctrl_chk #(
   parameter int REG_W      = 8,
   parameter int OSC_PD_BIT = 5,
   parameter int PD_BIT     = 6,
   parameter int SRST_BIT   = 7
) (
   input logic             clk,
   input logic             hw_reset,
   input logic             wr_en,
   input logic [REG_W-1:0] rd_data,
   input logic             ext_osc_sel,
   input logic             cmd_wr,
   input logic             core_clk_en,
   input logic             buf_run,
   input logic             core_rst,
   input logic             hw_rst_core,
   input logic [1:0]       op_mode,
   input logic             perp_mode,
   input logic             auto_pd
);
   AST_HW_CLEARS_PD: assert property (@(posedge clk)
      hw_reset |-> (rd_data[PD_BIT] == 1'b0 && rd_data[OSC_PD_BIT] == 1'b0)); // R1

   AST_PD_STOPS_CLK: assert property (@(posedge clk) disable iff (hw_reset)
      rd_data[PD_BIT] |-> (!core_clk_en && !buf_run)); // R2

   AST_OSC_STOPS_CLK: assert property (@(posedge clk) disable iff (hw_reset)
      (rd_data[OSC_PD_BIT] && !ext_osc_sel) |-> !core_clk_en); // R3

   AST_CLK_RESTARTS: assert property (@(posedge clk) disable iff (hw_reset)
      (!rd_data[PD_BIT] && (!rd_data[OSC_PD_BIT] || ext_osc_sel)) |-> core_clk_en); // R4

   AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (hw_reset)
      (rd_data[SRST_BIT] && !wr_en) |=> !rd_data[SRST_BIT]); // R7

   AST_SRST_DRIVES_RST: assert property (@(posedge clk) disable iff (hw_reset)
      rd_data[SRST_BIT] |-> core_rst); // R7

   AST_MODE_HELD: assert property (@(posedge clk) disable iff (hw_reset)
      !hw_rst_core |=> $stable(op_mode)); // R8

   AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (hw_reset)
      (!hw_rst_core && !(cmd_wr && core_clk_en)) |=> $stable({perp_mode, auto_pd})); // R10

   AST_FLAGS_CLEARED: assert property (@(posedge clk)
      hw_reset |-> (!perp_mode && !auto_pd)); // R9
endmodule

bind pwrdn_rst_ctrl pwrdn_rst_ctrl_chk #(
   .REG_W     (REG_W),
   .OSC_PD_BIT(OSC_PD_BIT),
   .PD_BIT    (PD_BIT),
   .SRST_BIT  (SRST_BIT)
) u_chk (
   .clk        (clk),
   .hw_reset   (hw_reset),
   .wr_en      (wr_en),
   .rd_data    (rd_data),
   .ext_osc_sel(ext_osc_sel),
   .cmd_wr     (cmd_wr),
   .core_clk_en(core_clk_en),
   .buf_run    (buf_run),
   .core_rst   (core_rst),
   .hw_rst_core(hw_rst_core),
   .op_mode    (op_mode),
   .perp_mode  (perp_mode),
   .auto_pd    (auto_pd)
);

// File: tb/pwrdn_rst_ctrl_test.sv
module pwrdn_rst_ctrl_test;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       hw_reset = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       ext_osc_sel = 1'b0;
   logic       strap_id = 1'b1;
   logic       strap_enc = 1'b0;
   logic       cmd_wr = 1'b0;
   logic       cmd_perp = 1'b0;
   logic       cmd_apd = 1'b0;
   logic       osc_run, buf_run, core_clk_en, core_rst, perp_mode, auto_pd;
   logic [1:0] op_mode;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pwrdn_rst_ctrl #(.SYNC_STAGES(SYNC)) uut (
      .clk(clk), .hw_reset(hw_reset), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .ext_osc_sel(ext_osc_sel), .strap_id(strap_id),
      .strap_enc(strap_enc), .cmd_wr(cmd_wr), .cmd_perp(cmd_perp),
      .cmd_apd(cmd_apd), .osc_run(osc_run), .buf_run(buf_run),
      .core_clk_en(core_clk_en), .core_rst(core_rst), .op_mode(op_mode),
      .perp_mode(perp_mode), .auto_pd(auto_pd)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic write_reg(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic flag_write(input logic p, input logic a);
      @(negedge clk);
      cmd_wr = 1'b1;
      cmd_perp = p;
      cmd_apd = a;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   // hardware reset with given straps; checks release timing and mode
   task automatic do_hw_reset(input logic id, input logic enc, input logic [1:0] exp_mode);
      @(negedge clk);
      strap_id = id;
      strap_enc = enc;
      hw_reset = 1'b1;
      #2;
      chk(core_rst, 1, "R5 core_rst immediate on hw_reset");
      repeat (3) @(negedge clk);
      hw_reset = 1'b0;
      for (int i = 1; i < SYNC; i++) begin
         @(negedge clk);
         chk(core_rst, 1, "R5 core_rst held during sync");
      end
      @(negedge clk);
      chk(core_rst, 0, "R5 core_rst released");
      chk(op_mode, exp_mode, "R6 strap decode");
   endtask

   task automatic t_reset_state;
      chk(rd_data, 8'h00, "R1 register after reset");
      chk(core_clk_en, 1, "R4 clock enabled after reset");
      chk({perp_mode, auto_pd}, 0, "R9 flags after reset");
      chk(op_mode, 2'b00, "R6 first mode from id=1");
   endtask

   task automatic t_pd_gate;
      write_reg(8'h40);
      chk(core_clk_en, 0, "R2 pd bit stops clock");
      chk(buf_run, 0, "R2 pd bit stops buffer");
      chk(osc_run, 1, "R3 osc runs with bit5 clear");
      write_reg(8'h03);
      chk(core_clk_en, 1, "R4 clock restarts after clear");
      chk(rd_data, 8'h03, "R4 static write while stopped");
   endtask

   task automatic t_osc_gate;
      ext_osc_sel = 1'b0;
      write_reg(8'h20);
      chk(core_clk_en, 0, "R3 bit5 stops clock, internal osc");
      chk(osc_run, 0, "R3 osc_run off");
      @(negedge clk);
      ext_osc_sel = 1'b1;
      #1;
      chk(core_clk_en, 1, "R3 bit5 no effect with external osc");
      write_reg(8'h60);
      chk(core_clk_en, 0, "R2 pd bit stops clock with external osc");
      ext_osc_sel = 1'b0;
      write_reg(8'h00);
      chk(core_clk_en, 1, "R4 clock back");
   endtask

   task automatic t_lockout_race;
      write_reg(8'h60);
      chk(core_clk_en, 0, "R2 both bits set");
      @(negedge clk);
      #3;
      hw_reset = 1'b1;
      #2;
      chk(rd_data, 8'h00, "R1 async clear without clock edge");
      chk(core_clk_en, 1, "R1 clock enable back during reset");
      @(negedge clk);
      hw_reset = 1'b0;
      repeat (SYNC + 1) @(negedge clk);
      chk(core_rst, 0, "R5 released after race");
   endtask

   task automatic t_flags_and_srst;
      flag_write(1'b1, 1'b1);
      chk({perp_mode, auto_pd}, 2'b11, "R10 flags load while clock on");
      write_reg(8'h40);
      flag_write(1'b0, 1'b0);
      chk({perp_mode, auto_pd}, 2'b11, "R10 flag write ignored while gated");
      write_reg(8'h00);
      // software reset with other bits set
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = 8'h82;
      @(negedge clk);
      wr_en = 1'b0;
      chk(core_rst, 1, "R7 soft reset pulse");
      chk(rd_data[7], 1, "R7 srst bit set one cycle");
      @(negedge clk);
      chk(core_rst, 0, "R7 soft reset pulse ends");
      chk(rd_data, 8'h02, "R7 srst self-clears, other bits kept");
      chk({perp_mode, auto_pd}, 2'b11, "R8 flags kept by soft reset");
      chk(op_mode, 2'b10, "R8 mode kept by soft reset");
      strap_id = 1'b1;
      repeat (2) @(negedge clk);
      chk(op_mode, 2'b10, "R6 strap change after release ignored");
      do_hw_reset(1'b0, 1'b1, 2'b01);
      chk({perp_mode, auto_pd}, 2'b00, "R9 hw reset clears flags");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      hw_reset = 1'b0;
      repeat (SYNC + 1) @(negedge clk);
      t_reset_state();
      t_pd_gate();
      t_osc_gate();
      t_lockout_race();
      do_hw_reset(1'b1, 1'b0, 2'b00);
      do_hw_reset(1'b0, 1'b0, 2'b10);
      t_flags_and_srst();
      do_hw_reset(1'b1, 1'b1, 2'b00);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule